// File: doc/BRIEF.md
# Timer Prescaler with Retrigger Synchronisation

This block produces the clock enable that paces a timer counter and decides when that counter is reloaded after a retrigger. A free-running prescale count advances on every base clock while the block is enabled. It raises a one-cycle tick each time the selected ratio has elapsed. The eight ratios are not evenly spaced: several powers of two are skipped. Both outputs are single-cycle strobes in the base clock domain, so the counter logic downstream needs no clock crossing.

A retrigger request asks the counter to reload or clear. A two-bit synchronisation mode sets when this happens. The reload can be issued at once, held until the next prescaled tick, or issued at once together with a restart of the prescale count. A lock-update flag can also be set automatically by retriggers and by counter wrap events. This lets the neighbouring logic freeze buffered values around those events.

Top module: `tmr_prescale_sync`

## Requirements
- R1: While `enable` is high, `tick` pulses once every N base cycles, where N follows `div_sel`: 0→1, 1→2, 2→4, 3→8, 4→16, 5→64, 6→256, 7→1024. The first tick after `enable` rises comes N cycles after the first enabled cycle.
- R2: With `div_sel` = 0 and `enable` high, `tick` is high on every cycle.
- R3: While `enable` is low, the prescale count is held at zero, and `tick` and `reload` stay low even if `retrig` is high.
- R4: In `sync_mode` 0, a `retrig` sampled high while enabled raises `reload` in the same cycle, so the counter acts on the next base clock edge. The prescale count is not disturbed.
- R5: In `sync_mode` 1, a retrigger is held pending, and `reload` rises only in a cycle where `tick` is high. A retrigger that coincides with a tick reloads in that cycle.
- R6: In `sync_mode` 1, further retriggers that arrive while a reload is pending merge into it, giving a single `reload` pulse.
- R7: In `sync_mode` 2, `reload` rises in the same cycle as the retrigger, and the prescale count restarts from zero at the next edge. The next tick follows N cycles later.
- R8: `sync_mode` 3 behaves exactly like mode 0.
- R9: With `auto_lock` high and `enable` high, a `retrig` or `ovf_evt` sets `lock_upd` from the next cycle. `lock_clr` clears it. A set wins over a clear in the same cycle.
- R10: With `auto_lock` low, retriggers and wrap events leave `lock_upd` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low holds the prescale count at zero |
| div_sel | input | 3 | Division ratio select |
| sync_mode | input | 2 | Retrigger synchronisation mode (0 immediate, 1 on tick, 2 immediate with prescale restart, 3 as 0) |
| retrig | input | 1 | Retrigger request, one cycle per event |
| ovf_evt | input | 1 | Counter overflow or underflow event from the counter |
| auto_lock | input | 1 | Lets events set the lock-update flag |
| lock_clr | input | 1 | Clears the lock-update flag |
| tick | output | 1 | Prescaled count enable, one base cycle wide |
| reload | output | 1 | Counter reload/clear strobe, one base cycle wide |
| lock_upd | output | 1 | Lock-update flag |

## Verification
The hardest case to reach is a retrigger whose effect depends on where the prescale count stands: a mode-1 reload that must wait for the tick, a second retrigger landing inside that wait, and a mode-2 restart that moves the following tick. The stimulus pulses `enable` low for one cycle to bring the count to a known zero. It then places each retrigger a fixed number of cycles later with divide-by-8, so the expected reload and tick cycles are known exactly. Tick spacing for all eight ratios is measured by a monitor that compares the gaps against the ratios queued by the driver.

// File: rtl/tmr_presc_pkg.sv
package tmr_presc_pkg;

    localparam int SEL_W  = 3;
    localparam int MODE_W = 2;
    localparam int CNT_W  = 10;

    typedef enum logic [MODE_W-1:0] {
        SYNC_BASE    = 2'd0,
        SYNC_TICK    = 2'd1,
        SYNC_RESTART = 2'd2,
        SYNC_RSVD    = 2'd3
    } sync_mode_e;

    // Terminal count (ratio minus one) for a select value.
    function automatic logic [CNT_W-1:0] term_of(input logic [SEL_W-1:0] sel);
        int unsigned sh;
        logic [CNT_W:0] full;
        case (sel)
            3'd0:    sh = 0;
            3'd1:    sh = 1;
            3'd2:    sh = 2;
            3'd3:    sh = 3;
            3'd4:    sh = 4;
            3'd5:    sh = 6;
            3'd6:    sh = 8;
            default: sh = 10;
        endcase
        full = (CNT_W+1)'(1) << sh;
        return CNT_W'(full - (CNT_W+1)'(1));
    endfunction

endpackage

// File: rtl/tmr_presc_div.sv
module tmr_presc_div
    import tmr_presc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             restart,
    output logic             tick
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [CNT_W-1:0] term;

    always_comb begin
        st_d = st_q;
        term = term_of(div_sel);
        // >= so a ratio lowered mid-count wraps at once
        tick = enable && (st_q.cnt >= term);
        if (!enable || restart || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tmr_retrig_sync.sv
module tmr_retrig_sync
    import tmr_presc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              retrig,
    input  logic [MODE_W-1:0] sync_mode,
    input  logic              tick,
    output logic              reload,
    output logic              restart
);

    typedef struct packed {
        logic pending;
    } rt_st_t;

    rt_st_t     st_d, st_q;
    sync_mode_e mode;

    always_comb begin
        st_d    = st_q;
        mode    = sync_mode_e'(sync_mode);
        reload  = 1'b0;
        restart = 1'b0;
        case (mode)
            SYNC_TICK: begin
                reload       = enable && tick && (st_q.pending || retrig);
                st_d.pending = enable && (st_q.pending || retrig) && !reload;
            end
            SYNC_RESTART: begin
                reload       = enable && retrig;
                restart      = enable && retrig;
                st_d.pending = 1'b0;
            end
            default: begin
                reload       = enable && retrig;
                st_d.pending = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tmr_lock_flag.sv
module tmr_lock_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic auto_lock,
    input  logic ovf_evt,
    input  logic retrig,
    input  logic lock_clr,
    output logic lock_upd
);

    typedef struct packed {
        logic lock;
    } lk_st_t;

    lk_st_t st_d, st_q;
    logic   set_ev;

    always_comb begin
        st_d   = st_q;
        set_ev = enable && auto_lock && (ovf_evt || retrig);
        if (set_ev) begin
            st_d.lock = 1'b1;
        end else if (lock_clr) begin
            st_d.lock = 1'b0;
        end
        lock_upd = st_q.lock;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tmr_prescale_sync.sv
module tmr_prescale_sync
    import tmr_presc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [SEL_W-1:0]  div_sel,
    input  logic [MODE_W-1:0] sync_mode,
    input  logic              retrig,
    input  logic              ovf_evt,
    input  logic              auto_lock,
    input  logic              lock_clr,
    output logic              tick,
    output logic              reload,
    output logic              lock_upd
);

    logic restart;

    tmr_presc_div u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .div_sel (div_sel),
        .restart (restart),
        .tick    (tick)
    );

    tmr_retrig_sync u_rt (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .retrig    (retrig),
        .sync_mode (sync_mode),
        .tick      (tick),
        .reload    (reload),
        .restart   (restart)
    );

    tmr_lock_flag u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .auto_lock (auto_lock),
        .ovf_evt   (ovf_evt),
        .retrig    (retrig),
        .lock_clr  (lock_clr),
        .lock_upd  (lock_upd)
    );

endmodule

// File: rtl/tmr_prescale_chk.sv
module tmr_prescale_chk
    import tmr_presc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic [SEL_W-1:0]  div_sel,
    input logic [MODE_W-1:0] sync_mode,
    input logic              retrig,
    input logic              ovf_evt,
    input logic              auto_lock,
    input logic              lock_clr,
    input logic              tick,
    input logic              reload,
    input logic              lock_upd
);

    // R2
    div1_every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && div_sel == 3'd0) |-> tick);

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!tick && !reload));

    // R4 R8
    base_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && retrig && sync_mode != 2'd1) |-> reload);

    // R5
    tick_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode == 2'd1 && reload) |-> tick);

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && retrig && sync_mode == 2'd2 && div_sel != 3'd0) |=> (!tick || div_sel == 3'd0));

    // R9
    lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && auto_lock && (retrig || ovf_evt)) |=> lock_upd);

    // R10
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_lock && !lock_clr) |=> $stable(lock_upd));

endmodule

bind tmr_prescale_sync tmr_prescale_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .div_sel   (div_sel),
    .sync_mode (sync_mode),
    .retrig    (retrig),
    .ovf_evt   (ovf_evt),
    .auto_lock (auto_lock),
    .lock_clr  (lock_clr),
    .tick      (tick),
    .reload    (reload),
    .lock_upd  (lock_upd)
);

// File: tb/sim_tmr_prescale_sync.sv
module sim_tmr_prescale_sync;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [2:0] div_sel = 3'd0;
    logic [1:0] sync_mode = 2'd0;
    logic       retrig = 1'b0;
    logic       ovf_evt = 1'b0;
    logic       auto_lock = 1'b0;
    logic       lock_clr = 1'b0;
    logic       tick, reload, lock_upd;

    int n_chk = 0;
    int n_err = 0;
    int exp_q[$];
    bit mon_on = 1'b0;
    int gap = 0;
    int rat[8] = '{1, 2, 4, 8, 16, 64, 256, 1024};

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_prescale_sync u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .div_sel   (div_sel),
        .sync_mode (sync_mode),
        .retrig    (retrig),
        .ovf_evt   (ovf_evt),
        .auto_lock (auto_lock),
        .lock_clr  (lock_clr),
        .tick      (tick),
        .reload    (reload),
        .lock_upd  (lock_upd)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic smp();
        @(negedge clk);
    endtask

    // Scoreboard monitor: tick gaps against queued ratios
    always @(negedge clk) begin
        if (mon_on) begin
            if (!enable) begin
                gap = 0;
            end else begin
                gap++;
                if (tick) begin
                    if (exp_q.size() > 0) begin
                        int e;
                        e = exp_q.pop_front();
                        if (div_sel == 3'd0) chk("R2 tick gap", gap, e);
                        else                 chk("R1 tick gap", gap, e);
                    end
                    gap = 0;
                end
            end
        end
    end

    // Immediate-reload modes: reload with the retrigger, tick unmoved
    task automatic run_base(input logic [1:0] mode, input string tag);
        cyc(); enable = 1'b0; div_sel = 3'd3; sync_mode = mode;
        cyc(); enable = 1'b1;              // cycle k
        cyc(); cyc();                      // k+2
        cyc(); retrig = 1'b1;              // k+3
        smp(); chk({tag, " reload with retrig"}, reload, 1);
        cyc(); retrig = 1'b0;              // k+4
        smp(); chk({tag, " reload one cycle"}, reload, 0);
        cyc(); cyc(); cyc();               // k+7
        smp(); chk({tag, " tick unmoved"}, tick, 1);
    endtask

    initial begin
        int cnt;
        // reset state
        smp();
        chk("R3 reset tick", tick, 0);
        chk("R3 reset reload", reload, 0);
        chk("R9 reset lock", lock_upd, 0);
        cyc(); rst_n = 1'b1;

        // R1 R2: spacing for all encodings
        mon_on = 1'b1;
        for (int s = 0; s < 8; s++) begin
            cyc(); enable = 1'b0; div_sel = 3'(s);
            cyc();
            for (int i = 0; i < 3; i++) exp_q.push_back(rat[s]);
            enable = 1'b1;
            wait (exp_q.size() == 0);
        end
        cyc(); enable = 1'b0;
        smp(); mon_on = 1'b0;

        // R3: disabled ignores retrigger
        cyc(); retrig = 1'b1; sync_mode = 2'd0;
        smp(); chk("R3 no reload while disabled", reload, 0);
        chk("R3 no tick while disabled", tick, 0);
        cyc(); retrig = 1'b0;

        run_base(2'd0, "R4");
        run_base(2'd3, "R8");

        // R5 R6: mode 1 waits for tick, merges retriggers
        cyc(); enable = 1'b0; div_sel = 3'd3; sync_mode = 2'd1;
        cyc(); enable = 1'b1;              // k
        cyc();                             // k+1
        cyc(); retrig = 1'b1;              // k+2
        smp(); chk("R5 reload held", reload, 0);
        cyc(); retrig = 1'b0;              // k+3
        smp(); chk("R5 reload still held", reload, 0);
        cyc(); retrig = 1'b1;              // k+4
        smp(); chk("R6 merged retrig held", reload, 0);
        cyc(); retrig = 1'b0;              // k+5
        cyc();                             // k+6
        smp(); chk("R5 reload before tick", reload, 0);
        cyc();                             // k+7
        smp(); chk("R5 tick", tick, 1);
        chk("R5 reload at tick", reload, 1);
        cnt = 0;
        for (int i = 0; i < 8; i++) begin  // k+8..k+15
            cyc(); smp();
            if (reload) cnt++;
        end
        chk("R6 single reload", cnt, 0);

        // R7: mode 2 restarts prescale count
        cyc(); enable = 1'b0; div_sel = 3'd3; sync_mode = 2'd2;
        cyc(); enable = 1'b1;              // k
        cyc(); cyc();                      // k+2
        cyc(); retrig = 1'b1;              // k+3
        smp(); chk("R7 reload with retrig", reload, 1);
        cyc(); retrig = 1'b0;              // k+4
        smp();
        cnt = 0;
        for (int i = 0; i < 6; i++) begin  // k+5..k+10
            cyc(); smp();
            if (tick) cnt++;
        end
        chk("R7 no tick before restart gap", cnt, 0);
        cyc();                             // k+11
        smp(); chk("R7 tick after restart", tick, 1);

        // R9 R10: lock flag
        cyc(); sync_mode = 2'd0; auto_lock = 1'b0; retrig = 1'b1; ovf_evt = 1'b1;
        cyc(); retrig = 1'b0; ovf_evt = 1'b0;
        smp(); chk("R10 lock untouched", lock_upd, 0);
        cyc(); auto_lock = 1'b1; ovf_evt = 1'b1;
        cyc(); ovf_evt = 1'b0;
        smp(); chk("R9 lock set by wrap", lock_upd, 1);
        cyc(); lock_clr = 1'b1;
        cyc(); lock_clr = 1'b0;
        smp(); chk("R9 lock cleared", lock_upd, 0);
        cyc(); lock_clr = 1'b1; retrig = 1'b1;
        cyc(); lock_clr = 1'b0; retrig = 1'b0;
        smp(); chk("R9 set wins over clear", lock_upd, 1);
        cyc(); auto_lock = 1'b0; retrig = 1'b1;
        cyc(); retrig = 1'b0;
        smp(); chk("R10 lock held", lock_upd, 1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule